// File: doc/BRIEF.md
# Serial Block-Transfer Configuration Slave

This block is a two-wire serial slave, running at standard-mode bit rates, that gives a host access to a 17-byte configuration file. It knows only two fixed bus addresses, one for writing and one for reading, and it has no register pointer. Every write stores bytes in order from byte 0. Every read returns a length byte first and then bytes in order from byte 0. The parallel image of the whole file is always present on `cfg_o`, so the surrounding logic reads its settings straight from that bus.

Both bus lines are sampled on the system clock through synchronizers. The slave only ever pulls SDA low: `sda_oe` enables the driver and `sda_o` is tied low, which gives an open-drain pair. The slave never stretches SCL, so SCL is an input only.

Five configuration bits are not stored at all. They read back strap levels that are captured while reset is held. Two register pairs load only as a unit.

There is no streaming data path. The parallel bus is a level-valued image, and all bus pacing comes from the master's SCL, so the block has no valid/ready interface and applies no back-pressure.

Top module: `cfg_serial_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and the slave ignores the bus until the next START.
- R2: In a write, the two bytes after the address (a command byte and a length byte) are acknowledged and discarded. The data bytes that follow land in byte 0, 1, 2, and so on, in that order.
- R3: Every data byte of a write is acknowledged. A STOP after any complete byte keeps all bytes already stored. Data bytes past index 16 are acknowledged and discarded.
- R4: In a read, the slave first sends the value of byte 8 (the read length). It then sends byte 0, 1, and so on, MSB first. A master ACK asks for the next byte; a master NACK ends the sending.
- R5: After as many data bytes as byte 8 holds, the slave releases SDA, so those bytes and any bytes past index 16 read as 0xFF.
- R6: Bytes 11/12 and bytes 13/14 load only as pairs. The first byte of a pair is held aside and takes effect together with the second byte. If a transfer ends after the first byte, neither byte changes.
- R7: After reset, bytes 1, 2 and 3 are 0xFF, byte 8 is 0x08, and all other bytes are 0x00, except for the strap bits named in R8.
- R8: These bits read back strap levels captured while `rst_n` is low: byte 1 bit 3 = `strap_fs_i[0]`, byte 3 bit 5 = `strap_fs_i[1]`, byte 3 bit 2 = `strap_fs_i[2]`, byte 5 bit 4 = `strap_fs_i[3]`, byte 7 bit 7 = `strap_en_i`. Writes never change them.
- R9: A repeated START in the middle of a transfer restarts address decoding, so a write can be followed directly by a read.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset; strap levels are captured while it is low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | SDA driver value, always low |
| sda_oe | output | 1 | SDA driver enable; high pulls the line low |
| strap_fs_i | input | 4 | Four frequency-select strap levels |
| strap_en_i | input | 1 | Enable strap level |
| cfg_o | output | 136 | Configuration image; byte k sits at bits 8k+7..8k |

## Verification
Writes are driven with byte patterns that differ at every index. They are sent at several lengths: three bytes, ending after the first byte of a pair, ending after the second, and running past the last index. Each length separates in-order storage, STOP handling, pair commit and the discarding of extra bytes. Reads are made with the default length, with a length of five, and with more bytes asked for than the length allows, which shows where the slave switches to 0xFF. Bad address bytes followed by extra clocked bytes, a write of all zeros over the strap bits, and a write that ends in a repeated START and a read-back round out the set.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } rx_ph_e;

  // Value a register takes at reset (strap bits are overlaid separately)
  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      1, 2, 3: return 8'hFF;
      8:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of a register that show strap levels instead of stored data
  function automatic logic [7:0] strap_mask(input int idx);
    case (idx)
      1:       return 8'h08;
      3:       return 8'h24;
      5:       return 8'h10;
      7:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] strap_bits(input int idx, input logic [3:0] fs, input logic en);
    case (idx)
      1:       return {4'b0000, fs[0], 3'b000};
      3:       return {2'b00, fs[1], 2'b00, fs[2], 2'b00};
      5:       return {3'b000, fs[3], 4'b0000};
      7:       return {en, 7'b0000000};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cfgslv_bus_fsm.sv
module cfgslv_bus_fsm
  import cfgslv_pkg::*;
#(
  parameter int         NREG    = 17,
  parameter int         IDXW    = 5,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic [7:0]      rd_data,
  input  logic [7:0]      rd_count,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic [7:0]      rd_idx,
  output logic            rd_mode,
  output bus_st_e         st
);

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  rx_ph_e          phase;
  logic [2:0]      bit_cnt;
  logic            byte_done;
  logic [7:0]      rx_sh;
  logic [7:0]      tx_sh;
  logic            m_ack;
  logic [IDXW-1:0] data_idx;
  logic [7:0]      rd_ptr;
  logic [7:0]      next_tx;

  // Bytes beyond the programmed length go out as all ones (line released)
  assign next_tx = (rd_ptr < rd_count) ? rd_data : 8'hFF;
  assign rd_idx  = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= 3'd0;
      byte_done <= 1'b0;
      rx_sh     <= 8'h00;
      tx_sh     <= 8'h00;
      m_ack     <= 1'b0;
      data_idx  <= '0;
      rd_ptr    <= 8'h00;
      rd_mode   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= 8'h00;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st        <= ST_RX;
        phase     <= PH_ADDR;
        bit_cnt   <= 3'd0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
        rd_mode   <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              sda_oe    <= 1'b1;
              st        <= ST_RX_ACK;
              unique case (phase)
                PH_ADDR: begin
                  if (rx_sh == WR_ADDR) begin
                    phase    <= PH_CMD;
                    data_idx <= '0;
                  end else if (rx_sh == RD_ADDR) begin
                    rd_mode <= 1'b1;
                    rd_ptr  <= 8'h00;
                  end else begin
                    sda_oe <= 1'b0;
                    st     <= ST_IDLE;
                  end
                end
                PH_CMD: phase <= PH_CNT;
                PH_CNT: phase <= PH_DATA;
                PH_DATA: begin
                  if (data_idx < IDXW'(NREG)) begin
                    wr_en    <= 1'b1;
                    wr_idx   <= data_idx;
                    wr_data  <= rx_sh;
                    data_idx <= data_idx + IDXW'(1);
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= 3'd0;
              if (rd_mode) begin
                tx_sh  <= rd_count;
                sda_oe <= ~rd_count[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                byte_done <= 1'b0;
                sda_oe    <= 1'b0;
                st        <= ST_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh   <= next_tx;
                sda_oe  <= ~next_tx[7];
                bit_cnt <= 3'd0;
                st      <= ST_TX;
                if (rd_ptr != 8'hFF) rd_ptr <= rd_ptr + 8'd1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile
  import cfgslv_pkg::*;
#(
  parameter int NREG  = 17,
  parameter int IDXW  = 5,
  parameter int CNT_IDX = 8,
  parameter int PAIR0 = 11,
  parameter int PAIR1 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        strap_fs_i,
  input  logic              strap_en_i,
  input  logic [7:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        cnt_o,
  output logic [NREG*8-1:0] regs_o
);

  logic [7:0] mem  [NREG];
  logic [7:0] view [NREG];
  logic [7:0] shadow;
  logic [3:0] fs_q;
  logic       en_q;
  logic       first_of_pair, second_of_pair;

  // Strap levels follow the pins while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q <= strap_fs_i;
      en_q <= strap_en_i;
    end
  end

  assign first_of_pair  = (wr_idx == IDXW'(PAIR0)) || (wr_idx == IDXW'(PAIR1));
  assign second_of_pair = (wr_idx == IDXW'(PAIR0 + 1)) || (wr_idx == IDXW'(PAIR1 + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reset_value(i);
      shadow <= 8'h00;
    end else if (wr_en) begin
      if (first_of_pair) begin
        shadow <= wr_data;
      end else if (second_of_pair) begin
        mem[wr_idx - IDXW'(1)] <= shadow;
        mem[wr_idx]            <= wr_data;
      end else begin
        mem[wr_idx] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign view[g] = (mem[g] & ~strap_mask(g)) | (strap_bits(g, fs_q, en_q) & strap_mask(g));
    assign regs_o[g*8 +: 8] = view[g];
  end

  assign rd_data = (rd_idx < 8'(NREG)) ? view[rd_idx[IDXW-1:0]] : 8'hFF;
  assign cnt_o   = view[CNT_IDX];

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgslv_pkg::*;
#(
  parameter int         NREG        = 17,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         CNT_IDX     = 8,
  parameter int         PAIR0       = 11,
  parameter int         PAIR1       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [3:0]        strap_fs_i,
  input  logic              strap_en_i,
  output logic [NREG*8-1:0] cfg_o
);

  localparam int IDXW = $clog2(NREG + 1);

  logic            scl_s, sda_s;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;
  logic [7:0]      rd_idx, rd_data, rd_count;
  logic            rd_mode;
  bus_st_e         st;

  cfgslv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );

  cfgslv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  cfgslv_bus_fsm #(
    .NREG(NREG), .IDXW(IDXW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .rd_data(rd_data), .rd_count(rd_count), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_mode(rd_mode), .st(st)
  );

  cfgslv_regfile #(
    .NREG(NREG), .IDXW(IDXW), .CNT_IDX(CNT_IDX), .PAIR0(PAIR0), .PAIR1(PAIR1)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .strap_fs_i(strap_fs_i), .strap_en_i(strap_en_i), .rd_idx(rd_idx),
    .rd_data(rd_data), .cnt_o(rd_count), .regs_o(cfg_o)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
  import cfgslv_pkg::*;
#(
  parameter int NREG  = 17,
  parameter int IDXW  = 5,
  parameter int PAIR0 = 11,
  parameter int PAIR1 = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_en,
  input logic [IDXW-1:0]   wr_idx,
  input logic              rd_mode,
  input bus_st_e           st,
  input logic [NREG*8-1:0] regs
);

  logic [NREG*8-1:0] ro_vec;
  for (genvar g = 0; g < NREG; g++) begin : g_ro
    assign ro_vec[g*8 +: 8] = strap_mask(g);
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i) else $error("drive began with SCL high"); // R10

  AST_REJECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_RX && st == ST_IDLE) |-> !sda_oe) else $error("drive after reject"); // R1

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode) else $error("store during read"); // R2

  AST_PAIR0_WITH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[PAIR0*8 +: 8]) |-> $past(wr_en && wr_idx == IDXW'(PAIR0 + 1)))
    else $error("first pair byte alone"); // R6

  AST_PAIR1_WITH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[PAIR1*8 +: 8]) |-> $past(wr_en && wr_idx == IDXW'(PAIR1 + 1)))
    else $error("first pair byte alone"); // R6

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs & ro_vec)) else $error("strap bit moved"); // R8

endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .NREG(NREG), .IDXW(IDXW), .PAIR0(PAIR0), .PAIR1(PAIR1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_en(wr_en),
  .wr_idx(wr_idx), .rd_mode(rd_mode), .st(st), .regs(cfg_o)
);

// File: tb/cfg_serial_slave_bench.sv
module cfg_serial_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 17;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] fs = 4'b0110;
  logic en = 1'b1;
  logic sda_line, sda_o, sda_oe, oe_prev = 1'b0;
  logic [NR*8-1:0] cfg;
  int n_chk = 0, n_fail = 0, viol = 0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [24];
  logic [7:0] pend;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave u_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe(sda_oe), .strap_fs_i(fs), .strap_en_i(en), .cfg_o(cfg)
  );

  // R10 monitor: the slave must start driving only while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] rom(input int i);
    case (i) 1: return 8'h08; 3: return 8'h24; 5: return 8'h10; 7: return 8'h80; default: return 8'h00; endcase
  endfunction

  function automatic logic [7:0] bdef(input int i);
    logic [7:0] v;
    v = (i >= 1 && i <= 3) ? 8'hFF : (i == 8) ? 8'h08 : 8'h00;
    case (i)
      1: v[3] = fs[0];
      3: begin v[5] = fs[1]; v[2] = fs[2]; end
      5: v[4] = fs[3];
      7: v[7] = en;
      default: ;
    endcase
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_wr(input logic b);
    clks(5); sda_m = b; clks(5); scl_m = 1'b1; clks(10); scl_m = 1'b0;
  endtask

  task automatic bit_rd(output logic b);
    clks(2); sda_m = 1'b1; clks(8); scl_m = 1'b1; clks(8); #2; b = sda_line; clks(2); scl_m = 1'b0;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; clks(5); scl_m = 1'b1; clks(10); sda_m = 1'b0; clks(10); scl_m = 1'b0;
  endtask

  task automatic i2c_stop;
    clks(2); sda_m = 1'b0; clks(5); scl_m = 1'b1; clks(10); sda_m = 1'b1; clks(10);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) bit_wr(d[i]);
    bit_rd(nak);
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_rd(d[i]);
    bit_wr(nak);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) chk(cfg[i*8 +: 8] === mdl[i], req, cfg[i*8 +: 8], mdl[i]);
  endtask

  // Block write of wbuf[0..n-1], updating the bench model from R2, R3, R6, R8
  task automatic do_write(input int n);
    logic nk;
    i2c_start;
    send_byte(8'hD2, nk); chk(!nk, "R1 write address ack", {7'd0, nk}, 8'd0);
    send_byte(8'hA5, nk); chk(!nk, "R2 command byte ack", {7'd0, nk}, 8'd0);
    send_byte(8'h3C, nk); chk(!nk, "R2 length byte ack", {7'd0, nk}, 8'd0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk); chk(!nk, "R3 data byte ack", {7'd0, nk}, 8'd0);
      if (i < NR) begin
        if (i == 11 || i == 13) pend = wbuf[i];
        else if (i == 12 || i == 14) begin
          mdl[i-1] = (pend & ~rom(i-1)) | (mdl[i-1] & rom(i-1));
          mdl[i]   = (wbuf[i] & ~rom(i)) | (mdl[i] & rom(i));
        end else mdl[i] = (wbuf[i] & ~rom(i)) | (mdl[i] & rom(i));
      end
    end
    i2c_stop;
  endtask

  task automatic do_read(input int n, input string req);
    logic nk;
    logic [7:0] d, e;
    i2c_start;
    send_byte(8'hD3, nk); chk(!nk, "R1 read address ack", {7'd0, nk}, 8'd0);
    recv_byte(n == 0, d); chk(d === mdl[8], "R4 length byte first", d, mdl[8]);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      e = (i < int'(mdl[8]) && i < NR) ? mdl[i] : 8'hFF;
      chk(d === e, req, d, e);
    end
    i2c_stop;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NR; i++) mdl[i] = bdef(i);
    check_regs("R7 R8 reset image");
    chk(sda_oe === 1'b0, "R7 idle drive", {7'd0, sda_oe}, 8'd0);
    do_read(9, "R5 default length 8 then released");
  endtask

  task automatic t_write_full;
    for (int i = 0; i < 24; i++) wbuf[i] = 8'(8'h31 + i * 29);
    wbuf[8] = 8'h05;
    do_write(19);
    check_regs("R2 R3 R6 full write plus extra bytes");
    do_read(7, "R4 R5 length 5 read");
  endtask

  task automatic t_partial;
    for (int i = 0; i < 24; i++) wbuf[i] = 8'(8'hC7 ^ (i * 13));
    wbuf[8] = 8'h06;
    do_write(3);
    check_regs("R3 stop after third byte");
  endtask

  task automatic t_pair;
    for (int i = 0; i < 24; i++) wbuf[i] = 8'(8'h5B + i * 71);
    wbuf[8] = 8'h0A;
    do_write(12);
    check_regs("R6 first of pair alone");
    for (int i = 0; i < 24; i++) wbuf[i] = 8'(8'h92 + i * 53);
    wbuf[8] = 8'h0F;
    do_write(14);
    check_regs("R6 first pair done second pair half");
    do_read(16, "R4 R6 pair readback");
  endtask

  task automatic t_bad_addr;
    logic nk;
    i2c_start;
    send_byte(8'hA4, nk); chk(nk, "R1 foreign address nak", {7'd0, nk}, 8'd1);
    send_byte(8'h00, nk); chk(nk, "R1 ignored until START", {7'd0, nk}, 8'd1);
    i2c_stop;
    i2c_start;
    send_byte(8'hD0, nk); chk(nk, "R1 near address nak", {7'd0, nk}, 8'd1);
    i2c_stop;
    check_regs("R1 nothing stored");
  endtask

  task automatic t_rep_start;
    logic nk;
    logic [7:0] d;
    i2c_start;
    send_byte(8'hD2, nk); chk(!nk, "R9 write address ack", {7'd0, nk}, 8'd0);
    send_byte(8'h00, nk);
    send_byte(8'h00, nk);
    send_byte(8'hE6, nk); chk(!nk, "R9 data ack", {7'd0, nk}, 8'd0);
    mdl[0] = 8'hE6;
    i2c_start;
    send_byte(8'hD3, nk); chk(!nk, "R9 read address after restart", {7'd0, nk}, 8'd0);
    recv_byte(1'b0, d); chk(d === mdl[8], "R9 length after restart", d, mdl[8]);
    recv_byte(1'b1, d); chk(d === 8'hE6, "R9 byte 0 after restart", d, 8'hE6);
    i2c_stop;
    check_regs("R9 only byte 0 changed");
  endtask

  task automatic t_straps;
    for (int i = 0; i < 24; i++) wbuf[i] = 8'h00;
    do_write(8);
    check_regs("R8 strap bits survive zero write");
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hFF;
    fs = 4'b1001; en = 1'b0;
    clks(4);
    do_write(8);
    check_regs("R8 straps ignored after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    report;
  end

  initial begin
    clks(6);
    rst_n = 1'b1;
    clks(10);
    t_reset;
    t_write_full;
    t_partial;
    t_pair;
    t_bad_addr;
    t_rep_start;
    t_straps;
    chk(viol == 0, "R10 drive only while SCL low", 8'(viol), 8'd0);
    report;
  end

endmodule